// File: doc/BRIEF.md
# Attention Request Sequencer

This block drives the handshake that hands an attention to a disk attachment. The attachment is reached through three byte-wide registers on a simple register bus: a control register that holds an interrupt-enable bit, a status register that holds a busy bit, and an attention register. A client hands over one request at a time: an attention type, a device number and the identifier of the interrupt being serviced, if any. The sequencer then runs four steps in a fixed order. It masks interrupts. It waits for the attachment to go idle. It writes the attention byte. It unmasks interrupts. It then answers the client with a result code.

The busy wait is bounded. If the attachment stays busy for the whole allowed number of status reads, the sequence stops with a timeout result. Steps three and four are not run, so interrupts stay masked. When the request acknowledges a reset-completed interrupt, the busy wait is skipped entirely. Attention types include command request, end of interrupt and reset of the attachment. Device number 7 addresses the attachment's own controller.

Top module: `attn_req_seq`

States, all named: `S_IDLE` (ready for a request), `S_MASK` (control write of zero), `S_POLL` (status reads), `S_ATTN` (attention write), `S_UNMASK` (control write of the enable bit), `S_REPLY` (one-cycle answer). Transitions:
- `S_IDLE`→`S_MASK` on an accepted request.
- `S_MASK`→`S_ATTN` on bus ack when the context is reset-completed, otherwise `S_MASK`→`S_POLL`.
- `S_POLL`→`S_ATTN` on a read that finds the attachment not busy.
- `S_POLL`→`S_REPLY` on the last allowed busy read.
- `S_ATTN`→`S_UNMASK` on bus ack.
- `S_UNMASK`→`S_REPLY` on bus ack.
- `S_REPLY`→`S_IDLE` always.

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `bus_req` is 0 and `ack_valid` is 0.
- R2: The first bus transfer after an accepted request is a write of 8'h00 to the control register (address 0).
- R3: Unless the context is reset-completed, the block reads the status register (address 2'd1) after the mask write. It keeps reading while bit `BUSY_BIT` (default 0) of the read data is 1. Other bits of the read data are ignored.
- R4: If `MAX_TRIES` consecutive status reads all report busy, the answer carries result 1 (timeout). The last of those reads is followed by no further bus transfer.
- R5: When `req_ctx` equals `RST_CTX` (default 4'hA), no status read is made, even while the attachment is busy.
- R6: The third step writes address 2'd2 with data {device[2:0], type[4:0]}. Device 7 passes through unchanged.
- R7: The fourth step writes the control register with only bit `IEN_BIT` (default 0) set, i.e. 8'h01.
- R8: `ack_valid` is a pulse exactly one cycle long. It rises the cycle after the bus ack of the final transfer, with result 0 for success.
- R9: A request is accepted only while `req_ready` is 1. A `req_valid` seen at any other time starts no transfers and produces no answer.
- R10: While `bus_req` is 1 and `bus_ack` is 0, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values.
- R11: A status read that finds the attachment not busy on the last allowed attempt continues to the attention write, and the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request strobe |
| req_ready | output | 1 | High while idle; the request is taken when both are high |
| req_type | input | 5 | Attention type code |
| req_dev | input | 3 | Device number (7 = controller) |
| req_ctx | input | 4 | Interrupt identifier being serviced |
| ack_valid | output | 1 | One-cycle answer pulse |
| ack_result | output | 1 | 0 = done, 1 = timeout |
| bus_req | output | 1 | Register transfer request, held until acked |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 2 | 0 control, 1 status, 2 attention |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transfer complete, one cycle |

## Verification
The delicate coincidence is the final permitted status read. In that one ack cycle the attempt limit is reached and the busy bit is sampled, and only the busy bit may decide between proceeding and timing out. Directed runs set the attachment model busy for exactly `MAX_TRIES-1` reads and for exactly `MAX_TRIES` reads. The bench judges the result code and the full transfer log of each run. A second overlap is a new request that lands while the answer pulse is out. The bench holds `req_valid` high through the whole sequence and its reply cycle. It then checks that only one answer and one transfer sequence appear.

// File: rtl/attn_pkg.sv
package attn_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_ATTN = 2'd2;

    localparam logic RES_DONE    = 1'b0;
    localparam logic RES_TIMEOUT = 1'b1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MASK,
        S_POLL,
        S_ATTN,
        S_UNMASK,
        S_REPLY
    } seq_state_t;

    typedef enum logic [1:0] {
        WSEL_ZERO,
        WSEL_ATTN,
        WSEL_IEN
    } wsel_t;
endpackage

// File: rtl/attn_try_ctr.sv
module attn_try_ctr #(
    parameter int MAX_TRIES = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_TRIES + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(MAX_TRIES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/attn_byte_fmt.sv
module attn_byte_fmt
    import attn_pkg::*;
#(
    parameter int TYPE_W  = 5,
    parameter int DEV_W   = 3,
    parameter int IEN_BIT = 0
) (
    input  wsel_t              sel,
    input  logic [TYPE_W-1:0]  atype,
    input  logic [DEV_W-1:0]   dev,
    output logic [DATA_W-1:0]  wdata
);
    localparam logic [DATA_W-1:0] IEN_MASK = DATA_W'(1) << IEN_BIT;

    always_comb begin
        unique case (sel)
            WSEL_ATTN: wdata = {dev, atype};
            WSEL_IEN:  wdata = IEN_MASK;
            default:   wdata = '0;
        endcase
    end
endmodule

// File: rtl/attn_req_seq.sv
module attn_req_seq
    import attn_pkg::*;
#(
    parameter int          MAX_TRIES = 10000,
    parameter int          TYPE_W    = 5,
    parameter int          DEV_W     = 3,
    parameter int          CTX_W     = 4,
    parameter int          BUSY_BIT  = 0,
    parameter int          IEN_BIT   = 0,
    parameter logic [3:0]  RST_CTX   = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [CTX_W-1:0]  req_ctx,
    output logic              ack_valid,
    output logic              ack_result,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ack
);
    localparam int WORD_W = TYPE_W + DEV_W;

    seq_state_t        state, state_nx;
    wsel_t             wsel;
    logic [TYPE_W-1:0] type_q;
    logic [DEV_W-1:0]  dev_q;
    logic              skip_q;
    logic              tmo_q;
    logic              accept;
    logic              busy_seen;
    logic              try_inc;
    logic              try_last;

    assign accept    = (state == S_IDLE) && req_valid;
    assign busy_seen = bus_rdata[BUSY_BIT];
    assign try_inc   = (state == S_POLL) && bus_ack && busy_seen;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Request capture and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            dev_q  <= '0;
            skip_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else if (accept) begin
            type_q <= req_type;
            dev_q  <= req_dev;
            skip_q <= (req_ctx == CTX_W'(RST_CTX));
            tmo_q  <= 1'b0;
        end else if (try_inc && try_last) begin
            tmo_q  <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = S_MASK;
            S_MASK:   if (bus_ack)   state_nx = skip_q ? S_ATTN : S_POLL;
            S_POLL: begin
                if (bus_ack) begin
                    if (!busy_seen)    state_nx = S_ATTN;
                    else if (try_last) state_nx = S_REPLY;
                end
            end
            S_ATTN:   if (bus_ack)   state_nx = S_UNMASK;
            S_UNMASK: if (bus_ack)   state_nx = S_REPLY;
            S_REPLY:                 state_nx = S_IDLE;
            default:                 state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        ack_valid  = 1'b0;
        ack_result = RES_DONE;
        bus_req    = 1'b0;
        bus_we     = 1'b0;
        bus_addr   = ADDR_CTRL;
        wsel       = WSEL_ZERO;
        unique case (state)
            S_IDLE:   req_ready = 1'b1;
            S_MASK: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
            end
            S_POLL: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_STAT;
            end
            S_ATTN: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = ADDR_ATTN;
                wsel     = WSEL_ATTN;
            end
            S_UNMASK: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
                wsel    = WSEL_IEN;
            end
            S_REPLY: begin
                ack_valid  = 1'b1;
                ack_result = tmo_q;
            end
            default: ;
        endcase
    end

    attn_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == S_IDLE),
        .inc   (try_inc),
        .last  (try_last)
    );

    logic [WORD_W-1:0] wbyte;

    attn_byte_fmt #(
        .TYPE_W  (TYPE_W),
        .DEV_W   (DEV_W),
        .IEN_BIT (IEN_BIT)
    ) u_fmt (
        .sel   (wsel),
        .atype (type_q),
        .dev   (dev_q),
        .wdata (wbyte)
    );

    assign bus_wdata = wbyte;
endmodule

// File: rtl/attn_req_seq_chk.sv
module attn_req_seq_chk #(
    parameter int          MAX_TRIES = 10000,
    parameter int          TYPE_W    = 5,
    parameter int          DEV_W     = 3,
    parameter int          CTX_W     = 4,
    parameter int          BUSY_BIT  = 0,
    parameter int          IEN_BIT   = 0,
    parameter logic [3:0]  RST_CTX   = 4'hA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [TYPE_W-1:0] req_type,
    input logic [DEV_W-1:0]  req_dev,
    input logic [CTX_W-1:0]  req_ctx,
    input logic              ack_valid,
    input logic              ack_result,
    input logic              bus_req,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              bus_ack
);
    localparam int CW = $clog2(MAX_TRIES + 1) + 1;

    logic              first_pend;
    logic [TYPE_W-1:0] type_c;
    logic [DEV_W-1:0]  dev_c;
    logic              skip_c;
    logic [CW-1:0]     busy_reads;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_pend <= 1'b0;
            type_c     <= '0;
            dev_c      <= '0;
            skip_c     <= 1'b0;
            busy_reads <= '0;
        end else if (req_valid && req_ready) begin
            first_pend <= 1'b1;
            type_c     <= req_type;
            dev_c      <= req_dev;
            skip_c     <= (req_ctx == CTX_W'(RST_CTX));
            busy_reads <= '0;
        end else if (bus_req && bus_ack) begin
            first_pend <= 1'b0;
            if (!bus_we && bus_rdata[BUSY_BIT]) busy_reads <= busy_reads + 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_req && !ack_valid));

    assert_first_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && first_pend) |-> (bus_we && bus_addr == 2'd0 && bus_wdata == 8'h00));

    assert_read_status_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> (bus_addr == 2'd1));

    assert_timeout_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_result) |-> (busy_reads == CW'(MAX_TRIES)));

    assert_skip_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> !skip_c);

    assert_attn_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == 2'd2) |-> (bus_wdata == {dev_c, type_c}));

    assert_unmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == 2'd0 && !first_pend) |-> (bus_wdata == (8'd1 << IEN_BIT)));

    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

    assert_busy_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req || ack_valid) |-> !req_ready);

    assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));
endmodule

bind attn_req_seq attn_req_seq_chk #(
    .MAX_TRIES (MAX_TRIES),
    .TYPE_W    (TYPE_W),
    .DEV_W     (DEV_W),
    .CTX_W     (CTX_W),
    .BUSY_BIT  (BUSY_BIT),
    .IEN_BIT   (IEN_BIT),
    .RST_CTX   (RST_CTX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_type   (req_type),
    .req_dev    (req_dev),
    .req_ctx    (req_ctx),
    .ack_valid  (ack_valid),
    .ack_result (ack_result),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_ack    (bus_ack)
);

// File: tb/attn_req_seq_tb.sv
`timescale 1ns/1ps
module attn_req_seq_tb;
    localparam int MAXT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [4:0] req_type = '0;
    logic [2:0] req_dev = '0;
    logic [3:0] req_ctx = '0;
    logic       ack_valid, ack_result;
    logic       bus_req, bus_we;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata = '0;
    logic       bus_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    attn_req_seq #(.MAX_TRIES(MAXT)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_dev(req_dev), .req_ctx(req_ctx),
        .ack_valid(ack_valid), .ack_result(ack_result),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // Attachment model and transfer log
    int         busy_left = 0;
    int         wait_cnt = 0;
    int         n_log = 0;
    logic       lg_we[64];
    logic [1:0] lg_addr[64];
    logic [7:0] lg_data[64];
    int         n_ack = 0;
    int         hold_viol = 0;
    logic       prev_pend = 1'b0;
    logic [10:0] prev_bus = '0;

    always @(posedge clk) begin
        if (bus_ack) begin
            bus_ack <= 1'b0;
        end else if (bus_req) begin
            if (wait_cnt > 0) begin
                wait_cnt <= wait_cnt - 1;
            end else begin
                bus_ack   <= 1'b1;
                bus_rdata <= {7'($urandom), 1'b0};
                if (!bus_we && bus_addr == 2'd1) begin
                    bus_rdata[0] <= (busy_left > 0);
                    if (busy_left > 0) busy_left <= busy_left - 1;
                end
                wait_cnt <= int'($urandom_range(0, 2));
            end
        end
        if (bus_req && bus_ack && n_log < 64) begin
            lg_we[n_log]   <= bus_we;
            lg_addr[n_log] <= bus_addr;
            lg_data[n_log] <= bus_wdata;
            n_log <= n_log + 1;
        end
        if (ack_valid) n_ack <= n_ack + 1;
        if (prev_pend && (!bus_req || prev_bus != {bus_we, bus_addr, bus_wdata}))
            hold_viol <= hold_viol + 1;
        prev_pend <= bus_req && !bus_ack;
        prev_bus  <= {bus_we, bus_addr, bus_wdata};
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_reads(input logic [3:0] ctx, input int busy);
        if (ctx == 4'hA) return 0;
        return (busy >= MAXT) ? MAXT : busy + 1;
    endfunction

    function automatic bit exp_tmo(input logic [3:0] ctx, input int busy);
        return (ctx != 4'hA) && (busy >= MAXT);
    endfunction

    task automatic run(input logic [4:0] t, input logic [2:0] d, input logic [3:0] c,
                       input int busy, input bit intrude);
        int  reads, idx, guard;
        bit  tmo;
        logic res;
        reads = exp_reads(c, busy);
        tmo   = exp_tmo(c, busy);
        @(negedge clk);
        busy_left = busy;
        n_log = 0;
        n_ack = 0;
        req_type = t; req_dev = d; req_ctx = c; req_valid = 1'b1;
        @(negedge clk);
        if (!intrude) req_valid = 1'b0;
        else begin req_type = ~t; req_dev = ~d; req_ctx = 4'hA; end
        guard = 0;
        while (!ack_valid && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        res = ack_result;
        chk(ack_valid, "R8 ack seen", ack_valid, 1);
        chk(res == tmo, tmo ? "R4 timeout result" : "R8 done result", res, tmo);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!ack_valid, "R8 one-cycle ack", ack_valid, 0);
        if (intrude) begin
            repeat (4) @(negedge clk);
            chk(n_ack == 1, "R9 intruding request ignored", n_ack, 1);
        end
        // transfer log
        chk(n_log == 1 + reads + (tmo ? 0 : 2), "R4/R5 transfer count", n_log, 1 + reads + (tmo ? 0 : 2));
        if (n_log >= 1)
            chk(lg_we[0] && lg_addr[0] == 2'd0 && lg_data[0] == 8'h00, "R2 mask write",
                {lg_we[0], lg_addr[0], lg_data[0]}, 11'h400);
        for (int i = 1; i <= reads && i < n_log; i++)
            chk(!lg_we[i] && lg_addr[i] == 2'd1, "R3 status read", {lg_we[i], lg_addr[i]}, 1);
        idx = 1 + reads;
        if (!tmo && n_log == idx + 2) begin
            chk(lg_we[idx] && lg_addr[idx] == 2'd2 && lg_data[idx] == {d, t}, "R6 attention byte",
                lg_data[idx], {d, t});
            chk(lg_we[idx+1] && lg_addr[idx+1] == 2'd0 && lg_data[idx+1] == 8'h01, "R7 unmask write",
                lg_data[idx+1], 8'h01);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(req_ready && !bus_req && !ack_valid, "R1 reset idle", {req_ready, bus_req, ack_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_req && !ack_valid, "R1 idle after reset", {req_ready, bus_req, ack_valid}, 3'b100);
        // R9: stray request does nothing unless ready; here check no ack without request
        repeat (3) @(negedge clk);
        chk(n_ack == 0 && !bus_req, "R9 no activity without request", n_ack, 0);

        run(5'h01, 3'd0, 4'h0, 0, 1'b0);           // immediate idle
        run(5'h02, 3'd7, 4'h3, 3, 1'b0);           // R6 controller device
        run(5'h04, 3'd1, 4'hA, 5, 1'b0);           // R5 skip while busy
        run(5'h03, 3'd1, 4'h1, MAXT - 1, 1'b0);    // R11 clear on last attempt
        run(5'h03, 3'd2, 4'h1, MAXT, 1'b0);        // R4 timeout
        run(5'h1F, 3'd5, 4'h6, 2, 1'b1);           // R9 intruding request
        for (int k = 0; k < 30; k++) begin
            logic [3:0] c;
            c = ($urandom_range(0, 3) == 0) ? 4'hA : 4'($urandom);
            run(5'($urandom), 3'($urandom), c, int'($urandom_range(0, MAXT + 2)), 1'b0);
        end
        chk(hold_viol == 0, "R10 bus held until ack", hold_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule